// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a register bus and the serial engine of an SPI controller. It owns a transmit queue and a receive queue, each of a parameterised depth between 2 and 31 words. It also owns the level, threshold and request-level registers, the status word, five interrupt sources with raw, mask and masked views, a per-bit clear register, and two DMA request lines. Software pushes transmit words and pops receive words through one data register. The shifter pulls transmit words through a pop port and deposits received words through a push port.

Threshold and request-level registers only keep a written value that is below the depth, so software can find the depth by writing growing values and reading them back. Clearing the controller enable empties both queues. The register map uses 4-bit word indices: 0 data, 1 transmit level, 2 receive level, 3 transmit threshold, 4 receive threshold, 5 status, 6 interrupt mask, 7 raw interrupts, 8 masked interrupts, 9 clear (write only, reads 0), 10 DMA control, 11 transmit request level, 12 receive request level. All other indices read 0.

Top module: `spi_fifo_stat_irq`

## Requirements
- R1: The status register reads, from bit 0 upward: core busy input, transmit queue full, transmit queue empty, receive queue empty, receive queue full.
- R2: Registers 1 and 2 read the current entry counts. Reading register 0 returns the oldest receive word and removes it, in first-in first-out order.
- R3: A bus write to register 0 while the transmit queue is full drops the word, leaves the level unchanged and sets sticky interrupt bit 1.
- R4: Reading register 0 while the receive queue is empty returns 0 and sets sticky bit 2. A core push into a full receive queue drops the word and sets sticky bit 3.
- R5: Raw bit 0 is 1 while the transmit level is at or below the transmit threshold. Raw bit 4 is 1 while the receive level is at or above the receive threshold.
- R6: A write to register 9 clears sticky bits per data bit: bit 0 clears bits 1, 2 and 3; bit 1 clears receive underflow (2); bit 2 clears receive overflow (3); bit 3 clears transmit overflow (1).
- R7: Register 8 equals raw AND mask (mask is register 6, bits 4:0). The irq output is the OR of register 8.
- R8: Registers 3, 4, 11 and 12 keep a written value only if it is below the depth. Otherwise they keep their old contents.
- R9: Register 10 bit 0 enables the receive request and bit 1 enables the transmit request. The transmit request is high while the transmit level is at or below register 11. The receive request is high while the receive level is above register 12.
- R10: While the controller enable is low, both queues are held empty, pushes are dropped and no overflow is flagged.
- R11: When a sticky event and its clear fall in the same cycle, the bit ends set.
- R12: tx_avail is high while the transmit queue is not empty, and tx_word shows its oldest word. tx_pop removes that word and is ignored when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_en | input | 1 | Controller enable; low flushes both queues |
| core_busy | input | 1 | Busy indication from the serial engine |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on register 0) |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr, valid in the same cycle |
| tx_pop | input | 1 | Core takes the oldest transmit word |
| tx_word | output | DW | Oldest transmit word |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Core delivers a received word |
| rx_word | input | DW | Received word |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The bench drives the transmit queue past full and the receive queue past empty and past full. A design that let a dropped word land, or that failed to flag it, would show a wrong level or a missing sticky bit. It probes the threshold registers with the depth itself. A design that stored it would read back the wrong value and would also break depth discovery. It puts a clear and a fresh overflow in the same cycle, and the set must win, or an event is lost. It pulses the enable low with data queued, where a design that failed to flush would still report levels. A long random phase compares levels, DMA requests, the combined interrupt and every read against a queue-based model on every clock.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    typedef enum logic [3:0] {
        A_DATA   = 4'd0,
        A_TXLVL  = 4'd1,
        A_RXLVL  = 4'd2,
        A_TXTHR  = 4'd3,
        A_RXTHR  = 4'd4,
        A_STAT   = 4'd5,
        A_IMASK  = 4'd6,
        A_IRAW   = 4'd7,
        A_ISTAT  = 4'd8,
        A_ICLR   = 4'd9,
        A_DMACTL = 4'd10,
        A_TXDRL  = 4'd11,
        A_RXDRL  = 4'd12
    } reg_addr_e;

    localparam int NIRQ = 5;
endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty,
    output logic                         ovf,
    output logic                         unf
);
    localparam int PW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [LW-1:0] cnt;
    } fst_t;

    fst_t q, d;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full  = (q.cnt == LW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign level = q.cnt;
    assign head  = empty ? '0 : mem[q.rp];
    assign ovf   = push && !flush && full;
    assign unf   = pop && empty;

    always_comb begin
        do_push = push && !flush && !full;
        do_pop  = pop && !flush && !empty;
        d       = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = wrap_inc(q.wp);
            if (do_pop)  d.rp = wrap_inc(q.rp);
            d.cnt = q.cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= push_data;
    end

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LW'(DEPTH));
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full);
    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/sfq_irq.sv
module sfq_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_low,
    input  logic       rx_high,
    input  logic       ev_txovf,
    input  logic       ev_rxunf,
    input  logic       ev_rxovf,
    input  logic       clr_wr,
    input  logic [3:0] clr_bits,
    input  logic [4:0] mask,
    output logic [4:0] raw,
    output logic [4:0] masked,
    output logic       irq
);
    typedef struct packed {
        logic txovf;
        logic rxunf;
        logic rxovf;
    } ist_t;

    ist_t q, d;
    logic c_txovf, c_rxunf, c_rxovf;

    always_comb begin
        c_txovf = clr_wr && (clr_bits[0] || clr_bits[3]);
        c_rxunf = clr_wr && (clr_bits[0] || clr_bits[1]);
        c_rxovf = clr_wr && (clr_bits[0] || clr_bits[2]);
        d.txovf = (q.txovf && !c_txovf) || ev_txovf;
        d.rxunf = (q.rxunf && !c_rxunf) || ev_rxunf;
        d.rxovf = (q.rxovf && !c_rxovf) || ev_rxovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign raw    = {rx_high, q.rxovf, q.rxunf, q.txovf, tx_low};
    assign masked = raw & mask;
    assign irq    = |masked;

    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txovf |=> raw[1]);
    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_bits[0] && !ev_txovf && !ev_rxunf && !ev_rxovf)
        |=> (raw[3:1] == 3'b000));
    a_r4_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[2] && !clr_wr) |=> raw[2]);
endmodule

// File: rtl/spi_fifo_stat_irq.sv
module spi_fifo_stat_irq #(
    parameter int DEPTH = 8,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_en,
    input  logic          core_busy,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [3:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_word,
    output logic          tx_avail,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_word,
    output logic          irq,
    output logic          dma_tx_req,
    output logic          dma_rx_req
);
    import sfq_pkg::*;

    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [LW-1:0]   txthr;
        logic [LW-1:0]   rxthr;
        logic [LW-1:0]   txdrl;
        logic [LW-1:0]   rxdrl;
        logic [NIRQ-1:0] mask;
        logic [1:0]      dmac;
    } cfg_t;

    cfg_t q, d;

    logic          wr_data, rd_data, clr_wr, fits;
    logic [LW-1:0] tx_lvl, rx_lvl;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          tx_ovf, tx_unf, rx_ovf, rx_unf;
    logic [DW-1:0] rx_head;
    logic [4:0]    raw, masked;

    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign rd_data = bus_rd && (bus_addr == A_DATA);
    assign clr_wr  = bus_wr && (bus_addr == A_ICLR);
    assign fits    = (bus_wdata < DW'(DEPTH));

    sfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!ctl_en),
        .push(wr_data), .push_data(bus_wdata), .pop(tx_pop),
        .head(tx_word), .level(tx_lvl), .full(tx_full), .empty(tx_empty),
        .ovf(tx_ovf), .unf(tx_unf));

    sfq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!ctl_en),
        .push(rx_push), .push_data(rx_word), .pop(rd_data),
        .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty),
        .ovf(rx_ovf), .unf(rx_unf));

    sfq_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .tx_low(tx_lvl <= q.txthr), .rx_high(rx_lvl >= q.rxthr),
        .ev_txovf(tx_ovf), .ev_rxunf(rx_unf), .ev_rxovf(rx_ovf),
        .clr_wr(clr_wr), .clr_bits(bus_wdata[3:0]), .mask(q.mask),
        .raw(raw), .masked(masked), .irq(irq));

    assign tx_avail   = !tx_empty;
    assign dma_tx_req = q.dmac[1] && (tx_lvl <= q.txdrl);
    assign dma_rx_req = q.dmac[0] && (rx_lvl > q.rxdrl);

    always_comb begin
        d = q;
        if (bus_wr) begin
            case (bus_addr)
                A_TXTHR:  if (fits) d.txthr = LW'(bus_wdata);
                A_RXTHR:  if (fits) d.rxthr = LW'(bus_wdata);
                A_TXDRL:  if (fits) d.txdrl = LW'(bus_wdata);
                A_RXDRL:  if (fits) d.rxdrl = LW'(bus_wdata);
                A_IMASK:  d.mask = bus_wdata[NIRQ-1:0];
                A_DMACTL: d.dmac = bus_wdata[1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA:   bus_rdata = rx_head;
            A_TXLVL:  bus_rdata = DW'(tx_lvl);
            A_RXLVL:  bus_rdata = DW'(rx_lvl);
            A_TXTHR:  bus_rdata = DW'(q.txthr);
            A_RXTHR:  bus_rdata = DW'(q.rxthr);
            A_STAT:   bus_rdata = DW'({rx_full, rx_empty, tx_empty, tx_full, core_busy});
            A_IMASK:  bus_rdata = DW'(q.mask);
            A_IRAW:   bus_rdata = DW'(raw);
            A_ISTAT:  bus_rdata = DW'(masked);
            A_DMACTL: bus_rdata = DW'(q.dmac);
            A_TXDRL:  bus_rdata = DW'(q.txdrl);
            A_RXDRL:  bus_rdata = DW'(q.rxdrl);
            default:  bus_rdata = '0;
        endcase
    end

    a_r8_thr_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TXTHR && !fits) |=> $stable(q.txthr));
    a_r9_dma_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dmac[1] && tx_empty) |-> dma_tx_req);
    a_r12_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_empty && !wr_data) |=> !tx_avail);
    a_r1_stat_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));
endmodule

// File: tb/spi_fifo_stat_irq_bench.sv
`timescale 1ns/1ps
module spi_fifo_stat_irq_bench;
    localparam int DEPTH = 8;
    localparam int DW    = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b1, busy = 1'b0, wr = 1'b0, rd = 1'b0, txpop = 1'b0, rxpush = 1'b0;
    logic [3:0] addr = '0;
    logic [DW-1:0] wdata = '0, rxword = '0;
    logic [DW-1:0] rdata, txword;
    logic txavail, irq, dtx, drx;

    int nchk = 0, nbad = 0;
    bit done = 0;
    string rtag = "R2";

    int txq[$], rxq[$];
    int m_txthr = 0, m_rxthr = 0, m_txdrl = 0, m_rxdrl = 0, m_mask = 0, m_dmac = 0;
    bit m_tovf = 0, m_runf = 0, m_rovf = 0;

    always #2.5 clk = ~clk;

    spi_fifo_stat_irq #(.DEPTH(DEPTH), .DW(DW)) u_spi_fifo_stat_irq (
        .clk(clk), .rst_n(rst_n), .ctl_en(en), .core_busy(busy),
        .bus_wr(wr), .bus_rd(rd), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .tx_pop(txpop), .tx_word(txword), .tx_avail(txavail),
        .rx_push(rxpush), .rx_word(rxword), .irq(irq),
        .dma_tx_req(dtx), .dma_rx_req(drx));

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int mraw();
        return int'(txq.size() <= m_txthr) | (int'(m_tovf) << 1) | (int'(m_runf) << 2)
             | (int'(m_rovf) << 3) | (int'(rxq.size() >= m_rxthr) << 4);
    endfunction

    function automatic int mread(int a);
        case (a)
            0: return rxq.size() > 0 ? rxq[0] : 0;
            1: return txq.size();
            2: return rxq.size();
            3: return m_txthr;
            4: return m_rxthr;
            5: return int'(busy) | (int'(txq.size() == DEPTH) << 1) | (int'(txq.size() == 0) << 2)
                    | (int'(rxq.size() == 0) << 3) | (int'(rxq.size() == DEPTH) << 4);
            6: return m_mask;
            7: return mraw();
            8: return mraw() & m_mask;
            10: return m_dmac;
            11: return m_txdrl;
            12: return m_rxdrl;
            default: return 0;
        endcase
    endfunction

    task automatic model_edge();
        int told = txq.size();
        int rold = rxq.size();
        bit wd = wr && addr == 0;
        bit rdd = rd && addr == 0;
        bit et = 0, eu = 0, eo = 0;
        int c = (wr && addr == 9) ? int'(wdata) : 0;
        if (rdd && rold == 0) eu = 1;
        if (!en) begin
            txq.delete(); rxq.delete();
        end else begin
            if (txpop && told > 0) void'(txq.pop_front());
            if (wd) begin if (told < DEPTH) txq.push_back(int'(wdata)); else et = 1; end
            if (rdd && rold > 0) void'(rxq.pop_front());
            if (rxpush) begin if (rold < DEPTH) rxq.push_back(int'(rxword)); else eo = 1; end
        end
        m_tovf = (m_tovf && !(c[0] || c[3])) || et;
        m_runf = (m_runf && !(c[0] || c[1])) || eu;
        m_rovf = (m_rovf && !(c[0] || c[2])) || eo;
        if (wr) begin
            case (addr)
                3: if (wdata < DEPTH) m_txthr = wdata;
                4: if (wdata < DEPTH) m_rxthr = wdata;
                11: if (wdata < DEPTH) m_txdrl = wdata;
                12: if (wdata < DEPTH) m_rxdrl = wdata;
                6: m_mask = wdata & 31;
                10: m_dmac = wdata & 3;
                default: ;
            endcase
        end
    endtask

    task automatic step();
        #1;
        if (rd) chk(rtag, int'(rdata), mread(int'(addr)));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R7 irq", int'(irq), int'((mraw() & m_mask) != 0));
        chk("R9 tx request", int'(dtx), int'(m_dmac[1] && txq.size() <= m_txdrl));
        chk("R9 rx request", int'(drx), int'(m_dmac[0] && rxq.size() > m_rxdrl));
        chk("R12 tx_avail", int'(txavail), int'(txq.size() > 0));
        if (txq.size() > 0) chk("R12 tx_word", int'(txword), txq[0]);
        wr = 0; rd = 0; txpop = 0; rxpush = 0;
    endtask

    task automatic bw(int a, int v);
        wr = 1; addr = 4'(a); wdata = DW'(v); step();
    endtask
    task automatic br(int a, string tag);
        rd = 1; addr = 4'(a); rtag = tag; step();
    endtask
    task automatic cpop();
        txpop = 1; step();
    endtask
    task automatic cpush(int v);
        rxpush = 1; rxword = DW'(v); step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        #750000;
        nbad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state: both queues empty -> status 0x0C
        rd = 1; addr = 5; #1; chk("R1 status after reset", int'(rdata), 12); rd = 0;
        busy = 1; br(5, "R1 busy bit"); busy = 0;
        // R2 levels
        bw(0, 16'h1111); bw(0, 16'h2222); bw(0, 16'h3333);
        br(1, "R2 tx level");
        // R8 probing
        bw(3, DEPTH); br(3, "R8 threshold rejects depth");
        bw(3, DEPTH - 1); br(3, "R8 threshold keeps depth-1");
        bw(11, 31); br(11, "R8 request level rejects");
        // R3 overflow
        for (int i = 0; i < DEPTH; i++) bw(0, 16'h4000 + i);
        br(5, "R1 tx full flag");
        br(7, "R3 raw overflow bit");
        br(1, "R3 level stays at depth");
        // R12 drain via core
        for (int i = 0; i < DEPTH + 2; i++) cpop();
        br(1, "R12 drained");
        // R2/R4 receive path
        for (int i = 0; i < DEPTH + 1; i++) cpush(16'hA000 + i);
        br(2, "R2 rx level");
        br(7, "R4 raw rx overflow");
        for (int i = 0; i < DEPTH; i++) br(0, "R2 rx order");
        br(0, "R4 empty read returns 0");
        br(7, "R4 raw rx underflow");
        // R5 thresholds
        bw(4, 3); cpush(1); cpush(2); br(7, "R5 rx below threshold");
        cpush(3); br(7, "R5 rx at threshold");
        bw(3, 1); bw(0, 5); bw(0, 6); br(7, "R5 tx above threshold");
        // R7 mask
        bw(6, 5'b10010); br(8, "R7 masked view");
        // R6 clears
        bw(9, 4'b0010); br(7, "R6 clear underflow only");
        bw(9, 4'b1000); br(7, "R6 clear tx overflow");
        bw(9, 4'b0001); br(7, "R6 clear all");
        // R11 set wins
        for (int i = 0; i < DEPTH; i++) cpush(i);
        wr = 1; addr = 9; wdata = 16'h4; rxpush = 1; rxword = 16'hBEEF; step();
        br(7, "R11 overflow survives clear");
        // R9 DMA
        bw(10, 3); bw(11, 2); bw(12, 4); br(10, "R9 dma control");
        for (int i = 0; i < 3; i++) br(0, "R9 rx drain");
        // R10 flush
        bw(0, 7); en = 0; step(); en = 1;
        br(1, "R10 tx flushed"); br(2, "R10 rx flushed");
        en = 0; bw(0, 9); en = 1; br(1, "R10 push dropped while disabled");
        // random phase
        bw(9, 1);
        for (int n = 0; n < 6000; n++) begin
            int r = int'($urandom_range(0, 99));
            en = ($urandom_range(0, 199) != 0);
            busy = 1'($urandom);
            txpop = ($urandom_range(0, 2) == 0);
            rxpush = ($urandom_range(0, 2) == 0);
            rxword = DW'($urandom);
            if (r < 30) begin wr = 1; addr = 0; wdata = DW'($urandom); end
            else if (r < 55) begin rd = 1; addr = 0; rtag = "R2 random pop"; end
            else if (r < 75) begin rd = 1; addr = 4'($urandom_range(1, 12)); rtag = "R5 random read"; end
            else if (r < 90) begin
                wr = 1; addr = 4'($urandom_range(3, 12));
                wdata = DW'($urandom_range(0, 12));
                if (addr == 5 || addr == 7 || addr == 8) wr = 0;
            end
            step();
        end
        en = 1;
        finish_run();
    end
endmodule